// File: doc/BRIEF.md
# ADC output code formatter

This block is the registered digital back end of a dual-channel 13-bit converter. Each clock cycle it takes one raw code per channel and returns an output word, an out-of-range flag, and an output-enable for the pad bus. The raw code is offset binary, with mid-scale at 4096. Each channel is handled independently. All channels share the coding, width-mode and output-enable controls.

Three width modes are available:

- **Full:** a 13-bit word.
- **Trimmed:** a 12-bit word on bits 12..1, with bit 0 held low.
- **Narrow:** a 12-bit word on bits 11..0 that covers half the raw span around mid-scale. Codes outside that window are clamped to the rails instead of wrapping.

Detection and clamping work on the offset-binary value. The optional two's complement conversion then inverts the top bit of the active word. Results appear one clock after the inputs are sampled. When the active-low enable is high, the data and flag outputs float.

Top module: `adc_code_formatter`

## Requirements
- R1: The word and flag outputs show the result for the inputs sampled at the previous rising clock edge (one cycle of latency).
- R2: While `rst` is high at a rising edge, the registered word becomes 4096 (0x1000) and the flag becomes 0. This holds regardless of the other inputs.
- R3: With `mode_sel` = 0 (full), the word equals the raw code. The flag is 1 exactly when the raw code is 0 or 8191.
- R4: With `mode_sel` = 1 (trimmed), bits 12..1 of the word equal raw bits 12..1 and bit 0 is 0. The flag is 1 exactly when raw bits 12..1 are all equal and raw bit 0 equals them too.
- R5: With `mode_sel` = 2 (narrow), bit 12 of the word is 0 and bits 11..0 carry a 12-bit value. A raw code of 6143 or more gives 4095 with the flag set. A raw code of 2048 or less gives 0 with the flag set. Any other code gives raw minus 2048 with the flag clear.
- R6: With `twos_sel` = 1, the active word's top bit is inverted after clamping. That is bit 12 in full and trimmed modes and bit 11 in narrow mode. With `twos_sel` = 0 the word stays offset binary.
- R7: Each channel's word and flag depend only on that channel's raw code and the shared controls.
- R8: `drv_en_o` equals the inverse of `oe_n`, and the data and flag buses are high impedance while `oe_n` is 1. The registers keep updating meanwhile, so the outputs are current as soon as `oe_n` returns to 0.
- R9: `mode_sel` = 3 behaves exactly like full mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Active-low output enable for the data and flag buses |
| twos_sel | input | 1 | 0 = offset binary output, 1 = two's complement output |
| mode_sel | input | 2 | 0 = full, 1 = trimmed, 2 = narrow, 3 = full |
| raw_i | input | NCH x W (2 x 13) | Raw offset-binary code per channel |
| dout_o | output | NCH x W (2 x 13) | Formatted word per channel, high impedance when disabled |
| oor_o | output | NCH (2) | Out-of-range flag per channel, high impedance when disabled |
| drv_en_o | output | 1 | High while the buses are driven |

## Verification
On every cycle, the assertions check several properties of the registered state:

- the mid-scale value after reset;
- the one-cycle copy of the raw code in plain full mode;
- the low bit held at zero in trimmed mode;
- the top bit held at zero in narrow mode;
- the rule that a raised flag in full offset-binary mode comes with a rail code.

The boundary behaviour needs the bench's scenarios. These include the exact window edges 2048 and 6143, the trimmed-mode codes 1 and 8190 that must not flag, the MSB inversion in each mode, and the alias mode. Two further cases also depend on the bench: channels driven with different codes, and the bus staying current across an output-disable interval.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        MODE_FULL   = 2'd0,
        MODE_TRIM   = 2'd1,
        MODE_NARROW = 2'd2,
        MODE_ALIAS  = 2'd3
    } width_mode_e;

    // Collapse the spare encoding onto full-width operation.
    function automatic width_mode_e fold_mode(input logic [1:0] sel);
        width_mode_e m;
        m = width_mode_e'(sel);
        if (m == MODE_ALIAS) begin
            m = MODE_FULL;
        end
        return m;
    endfunction

endpackage

// File: rtl/adc_range_det.sv
module adc_range_det
    import adc_fmt_pkg::*;
#(
    parameter int W = 13
) (
    input  logic [W-1:0]  code_i,
    input  width_mode_e   mode_i,
    output logic          over_o,
    output logic          under_o
);
    localparam int QUARTER = 2 ** (W - 2);
    localparam logic [W-1:0] WIN_LO = W'(QUARTER);
    localparam logic [W-1:0] WIN_HI = W'(3 * QUARTER - 1);

    logic full_over, full_under;
    logic trim_over, trim_under;
    logic narrow_over, narrow_under;
    logic upper_ones, upper_zero;

    always_comb begin
        full_over    = &code_i;
        full_under   = ~|code_i;
        upper_ones   = &code_i[W-1:1];
        upper_zero   = ~|code_i[W-1:1];
        trim_over    = upper_ones & code_i[0];
        trim_under   = upper_zero & ~code_i[0];
        narrow_over  = (code_i >= WIN_HI);
        narrow_under = (code_i <= WIN_LO);
    end

    always_comb begin
        unique case (mode_i)
            MODE_TRIM: begin
                over_o  = trim_over;
                under_o = trim_under;
            end
            MODE_NARROW: begin
                over_o  = narrow_over;
                under_o = narrow_under;
            end
            default: begin
                over_o  = full_over;
                under_o = full_under;
            end
        endcase
    end

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
    import adc_fmt_pkg::*;
#(
    parameter int W = 13
) (
    input  logic [W-1:0]  code_i,
    input  width_mode_e   mode_i,
    input  logic          over_i,
    input  logic          under_i,
    input  logic          twos_i,
    output logic [W-1:0]  word_o
);
    localparam int NW = W - 1;
    localparam logic [W-1:0] WIN_LO = W'(2 ** (W - 2));

    logic [W-1:0]  shifted;
    logic [NW-1:0] narrow_val;
    logic [W-1:0]  base;
    logic [W-1:0]  flip_mask;

    always_comb begin
        shifted = code_i - WIN_LO;
        if (over_i) begin
            narrow_val = '1;
        end else if (under_i) begin
            narrow_val = '0;
        end else begin
            narrow_val = shifted[NW-1:0];
        end
    end

    always_comb begin
        flip_mask = '0;
        unique case (mode_i)
            MODE_NARROW: begin
                base = {1'b0, narrow_val};
                flip_mask[NW-1] = twos_i;
            end
            MODE_TRIM: begin
                base = over_i ? '1 : (under_i ? '0 : code_i);
                base[0] = 1'b0;
                flip_mask[W-1] = twos_i;
            end
            default: begin
                base = over_i ? '1 : (under_i ? '0 : code_i);
                flip_mask[W-1] = twos_i;
            end
        endcase
        word_o = base ^ flip_mask;
    end

endmodule

// File: rtl/adc_code_formatter.sv
module adc_code_formatter
    import adc_fmt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int W   = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    oe_n,
    input  logic                    twos_sel,
    input  logic [1:0]              mode_sel,
    input  logic [NCH-1:0][W-1:0]   raw_i,
    output logic [NCH-1:0][W-1:0]   dout_o,
    output logic [NCH-1:0]          oor_o,
    output logic                    drv_en_o
);
    localparam logic [W-1:0] MID_CODE = W'(2 ** (W - 1));

    typedef struct packed {
        logic [NCH-1:0][W-1:0] word;
        logic [NCH-1:0]        oor;
    } fmt_state_t;

    fmt_state_t state_d, state_q;

    width_mode_e           mode_eff;
    logic [NCH-1:0]        over_w, under_w;
    logic [NCH-1:0][W-1:0] word_w;

    assign mode_eff = fold_mode(mode_sel);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        adc_range_det #(.W(W)) u_det (
            .code_i  (raw_i[ch]),
            .mode_i  (mode_eff),
            .over_o  (over_w[ch]),
            .under_o (under_w[ch])
        );

        adc_code_fmt #(.W(W)) u_fmt (
            .code_i  (raw_i[ch]),
            .mode_i  (mode_eff),
            .over_i  (over_w[ch]),
            .under_i (under_w[ch]),
            .twos_i  (twos_sel),
            .word_o  (word_w[ch])
        );
    end

    always_comb begin
        state_d = state_q;
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                state_d.word[c] = MID_CODE;
            end
            state_d.oor = '0;
        end else begin
            state_d.word = word_w;
            state_d.oor  = over_w | under_w;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign drv_en_o = ~oe_n;
    assign dout_o   = drv_en_o ? state_q.word : 'z;
    assign oor_o    = drv_en_o ? state_q.oor  : 'z;

endmodule

// File: rtl/adc_fmt_chk.sv
module adc_fmt_chk #(
    parameter int NCH = 2,
    parameter int W   = 13
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  twos_sel,
    input logic [1:0]            mode_sel,
    input logic [NCH-1:0][W-1:0] raw_i,
    input logic [NCH-1:0][W-1:0] word_q,
    input logic [NCH-1:0]        oor_q
);
    localparam logic [W-1:0] MID_CODE = W'(2 ** (W - 1));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        // R2: reset leaves mid-scale with the flag low
        p_reset_mid_r2: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (word_q[ch] == MID_CODE && !oor_q[ch]));

        // R1: plain full offset-binary mode copies the raw code one cycle later
        p_latency_full_r1: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mode_sel) == 2'd0 && !$past(twos_sel))
            |-> word_q[ch] == $past(raw_i[ch]));

        // R4: trimmed mode never drives the low bit
        p_trim_lsb_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mode_sel) == 2'd1) |-> !word_q[ch][0]);

        // R5: narrow mode keeps the top bit clear
        p_narrow_top_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mode_sel) == 2'd2) |-> !word_q[ch][W-1]);

        // R3: a raised flag in full offset-binary mode comes with a rail code
        p_flag_rail_r3: assert property (@(posedge clk) disable iff (rst)
            (oor_q[ch] && !$past(rst) && $past(mode_sel) == 2'd0 && !$past(twos_sel))
            |-> (word_q[ch] == '1 || word_q[ch] == '0));
    end

endmodule

bind adc_code_formatter adc_fmt_chk #(.NCH(NCH), .W(W)) u_fmt_chk (
    .clk      (clk),
    .rst      (rst),
    .twos_sel (twos_sel),
    .mode_sel (mode_sel),
    .raw_i    (raw_i),
    .word_q   (state_q.word),
    .oor_q    (state_q.oor)
);

// File: tb/tb_adc_code_formatter.sv
module tb_adc_code_formatter;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              oe_n = 1'b0;
    logic              twos_sel = 1'b0;
    logic [1:0]        mode_sel = 2'd0;
    logic [1:0][12:0]  raw_i = '0;
    wire  [1:0][12:0]  dout_o;
    wire  [1:0]        oor_o;
    wire               drv_en_o;

    int compared = 0;
    int mismatched = 0;
    int exp_word [2];
    int exp_flag [2];
    string exp_tag;

    adc_code_formatter dut (
        .clk      (clk),
        .rst      (rst),
        .oe_n     (oe_n),
        .twos_sel (twos_sel),
        .mode_sel (mode_sel),
        .raw_i    (raw_i),
        .dout_o   (dout_o),
        .oor_o    (oor_o),
        .drv_en_o (drv_en_o)
    );

    always #4 clk = ~clk;

    function automatic int ref_word(int raw, int md, bit tw);
        int w;
        if (md == 2) begin
            if (raw >= 6143) w = 4095;
            else if (raw <= 2048) w = 0;
            else w = raw - 2048;
            if (tw) w = w ^ 2048;
        end else if (md == 1) begin
            w = (raw / 2) * 2;
            if (tw) w = w ^ 4096;
        end else begin
            w = raw;
            if (tw) w = w ^ 4096;
        end
        return w;
    endfunction

    function automatic int ref_flag(int raw, int md);
        if (md == 2) return (raw >= 6143 || raw <= 2048) ? 1 : 0;
        if (md == 1) return (((raw / 2) == 4095 && raw % 2 == 1) ||
                             ((raw / 2) == 0 && raw % 2 == 0)) ? 1 : 0;
        return (raw == 0 || raw == 8191) ? 1 : 0;
    endfunction

    // One cycle: drive at a negedge, let the posedge pass, compare at the next negedge.
    task automatic cycle(input bit r, input bit oe, input bit tw, input int md,
                         input int ra, input int rb);
        rst = r; oe_n = oe; twos_sel = tw; mode_sel = md[1:0];
        raw_i[0] = ra[12:0]; raw_i[1] = rb[12:0];
        if (r) begin
            exp_tag = "R2";
            for (int c = 0; c < 2; c++) begin exp_word[c] = 4096; exp_flag[c] = 0; end
        end else begin
            exp_tag = (md == 2) ? "R5" : (md == 1) ? "R4" : (md == 3) ? "R9" : "R3";
            if (tw) exp_tag = {exp_tag, "/R6"};
            exp_word[0] = ref_word(ra, md, tw); exp_flag[0] = ref_flag(ra, md);
            exp_word[1] = ref_word(rb, md, tw); exp_flag[1] = ref_flag(rb, md);
        end
        @(negedge clk);
        compared++;
        if (drv_en_o !== !oe) begin
            mismatched++;
            $display("FAIL R8 drv_en actual=%0b expected=%0b", drv_en_o, !oe);
        end
        if (!oe) begin
            for (int c = 0; c < 2; c++) begin
                compared++;
                if (int'(dout_o[c]) != exp_word[c] || int'(oor_o[c]) != exp_flag[c]) begin
                    mismatched++;
                    $display("FAIL %s/R1/R7 ch%0d raw=%0d word actual=%0d expected=%0d flag actual=%0b expected=%0b",
                             exp_tag, c, (c == 0) ? ra : rb, dout_o[c], exp_word[c],
                             oor_o[c], exp_flag[c]);
                end
            end
        end
    endtask

    int corners [14] = '{0, 1, 2, 2047, 2048, 2049, 4095, 4096,
                         4097, 6142, 6143, 6144, 8190, 8191};

    initial begin
        @(negedge clk);
        // R2: reset state, with hostile inputs applied
        cycle(1, 0, 1, 2, 8191, 0);
        cycle(1, 0, 0, 0, 123, 8000);
        // R3 R4 R5 R6 R9: every mode and coding against the corner codes
        for (int md = 0; md < 4; md++) begin
            for (int tw = 0; tw < 2; tw++) begin
                for (int k = 0; k < 14; k++) begin
                    cycle(0, 0, tw[0], md, corners[k], corners[13 - k]);
                end
            end
        end
        // R7: one channel on a rail, the other at mid-scale
        cycle(0, 0, 0, 0, 8191, 4096);
        cycle(0, 0, 0, 2, 4096, 100);
        // R8: outputs disabled while data keeps flowing, then re-enabled
        cycle(0, 1, 0, 0, 10, 20);
        cycle(0, 1, 1, 2, 7000, 3000);
        cycle(0, 0, 0, 1, 8190, 1);
        // R2 mid-run reset
        cycle(1, 0, 0, 1, 5, 5);
        // Random traffic across all controls
        for (int n = 0; n < 600; n++) begin
            cycle(($urandom_range(0, 49) == 0), ($urandom_range(0, 9) == 0),
                  $urandom_range(0, 1) == 1, $urandom_range(0, 3),
                  $urandom_range(0, 8191), $urandom_range(0, 8191));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule